// File: doc/BRIEF.md
# Eight-Bit Floating-Point Multiplier

This block multiplies two 8-bit floating-point words and returns one rounded 8-bit word together with three exception flags. A word holds a sign bit at position 7, a 4-bit biased exponent in bits 6:3 with bias 7, and a 3-bit fraction in bits 2:0. Exponent field 0 marks a subnormal (exponent 1 − 7, no hidden bit), field 15 marks infinity (zero fraction) or not-a-number (nonzero fraction), and every other field is a normal number with a hidden leading one.

The unit is a two-stage pipeline. The first stage decodes both operands, forms the exact 8-bit significand product, normalizes it with a leading-one search and sorts out the special cases. The second stage shifts results that fall below the normal range into subnormal position, rounds to nearest with ties to even, and packs the word. A new pair may be presented every cycle on `in_valid_i`. The matching result appears with `out_valid_o` exactly two clock edges later.

Top module: `fp8_mul`

## Requirements
- R1: A pair sampled with `in_valid_i` high on a rising edge gives `out_valid_o` high after the second rising edge that follows. A cycle with `in_valid_i` low gives `out_valid_o` low two edges later. Pairs are accepted back to back.
- R2: Every result that is not NaN carries bit 7 equal to the XOR of the two operand sign bits. This includes zeros and infinities.
- R3: Operands are decoded with bias 7. Exponent field 0 means exponent −6 and no hidden bit. Fields 1 to 14 add a hidden one above the 3-bit fraction.
- R4: A finite nonzero product is rounded to the nearest representable value. On an exact tie, the result with fraction bit 0 equal to 0 is chosen.
- R5: A product whose exact magnitude is below 2^-6 is delivered as a subnormal, as zero, or as the smallest normal if rounding carries it there. `underflow_o` is set exactly when such a product is also inexact.
- R6: When the rounded magnitude would reach 2^8 or more, the result is infinity (bits 6:0 = 7'h78) with the XOR sign, and `overflow_o` and `inexact_o` are both set.
- R7: `inexact_o` is set exactly when the delivered finite value differs from the exact product, or when overflow occurred.
- R8: A NaN operand, or zero times infinity, yields the canonical quiet NaN 8'h7C with all flags clear.
- R9: Infinity times a nonzero non-NaN value yields infinity with the XOR sign and all flags clear.
- R10: Zero (either sign) times a finite value yields zero with the XOR sign and all flags clear.
- R11: While `rst_ni` is low, `out_valid_o`, `result_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair valid |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand |
| out_valid_o | output | 1 | Result valid, two edges after the pair |
| result_o | output | 8 | Rounded product |
| overflow_o | output | 1 | Result overflowed to infinity |
| underflow_o | output | 1 | Result tiny before rounding and inexact |
| inexact_o | output | 1 | Result differs from exact product |

## Verification
The clocked properties assume that `in_valid_i` and both operands are known (never X or Z) on every rising edge after reset. The sign property also assumes that the operands held on the sampled edge are the ones whose result appears two edges later. The stimulus keeps within both assumptions. It drives every input from a single process on the falling edge, holds each value for a full cycle, and inserts idle cycles on a fixed pattern rather than leaving inputs undriven. The sweep covers all 65,536 operand pairs, so every special-value pairing, every subnormal combination and every rounding tie is reached.

// File: rtl/fp8_mul_pkg.sv
package fp8_mul_pkg;
  parameter int EXP_W  = 4;
  parameter int FRAC_W = 3;

  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int LZ_W   = $clog2(PROD_W);
  localparam int EXPS_W = EXP_W + 3;
  // biased result exponent = ea + eb + lead - E_OFS
  localparam int E_OFS  = BIAS + 2 * FRAC_W;
  localparam int SH_CAP = SIG_W + 1;
  localparam int WIDE_W = PROD_W + SH_CAP;

  localparam logic [MAG_W-1:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [MAG_W-1:0] QNAN_MAG = {{EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {SP_NONE, SP_NAN, SP_INF, SP_ZERO} special_e;

  typedef struct packed {
    logic              sign;
    logic              is_zero;
    logic              is_inf;
    logic              is_nan;
    logic [SIG_W-1:0]  sig;
    logic [EXP_W-1:0]  exp_eff;
  } operand_t;
endpackage

// File: rtl/fp8_mul_unpack.sv
module fp8_mul_unpack
  import fp8_mul_pkg::*;
(
  input  logic [FP_W-1:0] word_i,
  output operand_t        op_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_zero;

  assign exp_f     = word_i[FP_W-2 -: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = &exp_f;
  assign frac_zero = (frac_f == '0);

  always_comb begin
    op_o.sign    = word_i[FP_W-1];
    op_o.is_zero = exp_zero & frac_zero;
    op_o.is_inf  = exp_ones & frac_zero;
    op_o.is_nan  = exp_ones & ~frac_zero;
    op_o.sig     = {~exp_zero, frac_f};
    // subnormals share the exponent of field value 1
    op_o.exp_eff = exp_zero ? EXP_W'(1) : exp_f;
  end
endmodule

// File: rtl/fp8_mul_front.sv
module fp8_mul_front
  import fp8_mul_pkg::*;
(
  input  operand_t                  a_i,
  input  operand_t                  b_i,
  output special_e                  sp_o,
  output logic                      sign_o,
  output logic [PROD_W-1:0]         norm_o,
  output logic signed [EXPS_W-1:0]  exp_o
);
  logic [PROD_W-1:0] prod;
  logic [LZ_W-1:0]   lead;

  assign prod   = PROD_W'(a_i.sig) * PROD_W'(b_i.sig);
  assign sign_o = a_i.sign ^ b_i.sign;

  always_comb begin
    lead = '0;
    for (int i = 0; i < PROD_W; i++) begin
      if (prod[i]) lead = LZ_W'(i);
    end
  end

  assign norm_o = prod << (PROD_W - 1 - int'(lead));
  assign exp_o  = EXPS_W'(int'(a_i.exp_eff) + int'(b_i.exp_eff) + int'(lead) - E_OFS);

  always_comb begin
    if (a_i.is_nan || b_i.is_nan || (a_i.is_inf && b_i.is_zero) || (a_i.is_zero && b_i.is_inf))
      sp_o = SP_NAN;
    else if (a_i.is_inf || b_i.is_inf)
      sp_o = SP_INF;
    else if (a_i.is_zero || b_i.is_zero)
      sp_o = SP_ZERO;
    else
      sp_o = SP_NONE;
  end

  // R3
  always_comb begin
    if (sp_o == SP_NONE) norm_msb_chk: assert (norm_o[PROD_W-1] == 1'b1);
  end
endmodule

// File: rtl/fp8_mul_round.sv
module fp8_mul_round
  import fp8_mul_pkg::*;
(
  input  logic [PROD_W-1:0]         norm_i,
  input  logic signed [EXPS_W-1:0]  exp_i,
  output logic [MAG_W-1:0]          mag_o,
  output logic                      ovf_o,
  output logic                      unf_o,
  output logic                      inx_o
);
  logic [WIDE_W-1:0] wide;
  logic [SIG_W-1:0]  kept;
  logic              guard, sticky, inc, tiny;
  int                e_int, sh, code;

  always_comb begin
    e_int = int'(exp_i);
    tiny  = (e_int < 1);
    sh    = tiny ? (1 - e_int) : 0;
    if (sh > SH_CAP) sh = SH_CAP;
    wide   = {norm_i, {SH_CAP{1'b0}}} >> sh;
    kept   = wide[WIDE_W-1 -: SIG_W];
    guard  = wide[WIDE_W-1-SIG_W];
    sticky = |wide[WIDE_W-2-SIG_W:0];
    inc    = guard & (sticky | kept[0]);
    // exponent step and significand add share one carry chain
    code   = ((tiny ? 0 : e_int - 1) << FRAC_W) + int'(kept) + int'(inc);
    ovf_o  = (code >= int'(INF_MAG));
    mag_o  = ovf_o ? INF_MAG : MAG_W'(code);
    inx_o  = guard | sticky | ovf_o;
    unf_o  = tiny & (guard | sticky);
  end

  // R5
  always_comb begin
    if (tiny) tiny_no_ovf_chk: assert (!ovf_o);
  end
endmodule

// File: rtl/fp8_mul.sv
module fp8_mul
  import fp8_mul_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [FP_W-1:0] op_a_i,
  input  logic [FP_W-1:0] op_b_i,
  output logic            out_valid_o,
  output logic [FP_W-1:0] result_o,
  output logic            overflow_o,
  output logic            underflow_o,
  output logic            inexact_o
);
  logic [FP_W-1:0] words [2];
  operand_t        ops   [2];

  assign words[0] = op_a_i;
  assign words[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fp8_mul_unpack u_unp (.word_i(words[g]), .op_o(ops[g]));
  end

  special_e                 sp_d;
  logic                     sign_d;
  logic [PROD_W-1:0]        norm_d;
  logic signed [EXPS_W-1:0] exp_d;

  fp8_mul_front u_front (
    .a_i   (ops[0]),
    .b_i   (ops[1]),
    .sp_o  (sp_d),
    .sign_o(sign_d),
    .norm_o(norm_d),
    .exp_o (exp_d)
  );

  logic                     v1_q;
  special_e                 sp1_q;
  logic                     sign1_q;
  logic [PROD_W-1:0]        norm1_q;
  logic signed [EXPS_W-1:0] exp1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      sp1_q   <= SP_ZERO;
      sign1_q <= 1'b0;
      norm1_q <= '0;
      exp1_q  <= '0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        sp1_q   <= sp_d;
        sign1_q <= sign_d;
        norm1_q <= norm_d;
        exp1_q  <= exp_d;
      end
    end
  end

  logic [MAG_W-1:0] mag_r;
  logic             ovf_r, unf_r, inx_r;

  fp8_mul_round u_round (
    .norm_i(norm1_q),
    .exp_i (exp1_q),
    .mag_o (mag_r),
    .ovf_o (ovf_r),
    .unf_o (unf_r),
    .inx_o (inx_r)
  );

  logic [FP_W-1:0] res_d;
  logic            ovf_d, unf_d, inx_d;

  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    inx_d = 1'b0;
    unique case (sp1_q)
      SP_NAN:  res_d = {1'b0, QNAN_MAG};
      SP_INF:  res_d = {sign1_q, INF_MAG};
      SP_ZERO: res_d = {sign1_q, {MAG_W{1'b0}}};
      default: begin
        res_d = {sign1_q, mag_r};
        ovf_d = ovf_r;
        unf_d = unf_r;
        inx_d = inx_r;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      out_valid_o <= v1_q;
      if (v1_q) begin
        result_o    <= res_d;
        overflow_o  <= ovf_d;
        underflow_o <= unf_d;
        inexact_o   <= inx_d;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);
  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);
  // R2
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && result_o[MAG_W-1:0] != QNAN_MAG) |->
      result_o[FP_W-1] == ($past(op_a_i[FP_W-1], 2) ^ $past(op_b_i[FP_W-1], 2)));
  // R6
  ovf_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && overflow_o) |-> (result_o[MAG_W-1:0] == INF_MAG && inexact_o));
  // R5
  unf_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && underflow_o) |->
      (inexact_o && !overflow_o && result_o[FP_W-2 -: EXP_W] <= EXP_W'(1)));
  // R8
  nan_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (&result_o[FP_W-2 -: EXP_W]) && result_o[FRAC_W-1:0] != '0) |->
      (result_o == {1'b0, QNAN_MAG} && !overflow_o && !underflow_o && !inexact_o));
endmodule

// File: tb/fp8_mul_tb.sv
`timescale 1ns/1ps
module fp8_mul_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       in_valid;
  logic [7:0] op_a, op_b;
  logic       out_valid;
  logic [7:0] result;
  logic       ovf, unf, inx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fp8_mul dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .out_valid_o(out_valid),
    .result_o   (result),
    .overflow_o (ovf),
    .underflow_o(unf),
    .inexact_o  (inx)
  );

  // grid value of magnitude code c, in units of 2^-18
  function automatic longint grid(int c);
    if (c < 8) return longint'(c) << 9;
    return longint'(8 + (c & 7)) << ((c >> 3) + 8);
  endfunction

  function automatic void ref_mul(input logic [7:0] a, input logic [7:0] b,
                                  output logic [7:0] r, output logic ov,
                                  output logic un, output logic ix,
                                  output string tag);
    int ea, eb, sa, sb, pick, lo_c;
    logic sg, na, nb, ia, ib, za, zb;
    longint x, lo, hi;
    ea = int'(a[6:3]); eb = int'(b[6:3]);
    na = (ea == 15) && (a[2:0] != 0); nb = (eb == 15) && (b[2:0] != 0);
    ia = (ea == 15) && (a[2:0] == 0); ib = (eb == 15) && (b[2:0] == 0);
    za = (ea == 0) && (a[2:0] == 0);  zb = (eb == 0) && (b[2:0] == 0);
    sg = a[7] ^ b[7];
    ov = 0; un = 0; ix = 0;
    if (na || nb || (ia && zb) || (za && ib)) begin
      r = 8'h7C; tag = "R8";
    end else if (ia || ib) begin
      r = {sg, 7'h78}; tag = "R9 R2";
    end else if (za || zb) begin
      r = {sg, 7'h00}; tag = "R10 R2";
    end else begin
      sa = (ea == 0) ? int'(a[2:0]) : 8 + int'(a[2:0]);
      sb = (eb == 0) ? int'(b[2:0]) : 8 + int'(b[2:0]);
      if (ea == 0) ea = 1;
      if (eb == 0) eb = 1;
      x = longint'(sa * sb) << (ea + eb - 2);
      lo_c = 0;
      for (int c = 0; c < 121; c++) if (grid(c) <= x) lo_c = c;
      if (lo_c >= 120) pick = 120;
      else begin
        lo = grid(lo_c); hi = grid(lo_c + 1);
        if (2 * x < lo + hi) pick = lo_c;
        else if (2 * x > lo + hi) pick = lo_c + 1;
        else pick = (lo_c % 2 == 0) ? lo_c : lo_c + 1;
      end
      ix = (x != grid(lo_c));
      if (pick >= 120) begin
        ov = 1; ix = 1; r = {sg, 7'h78}; tag = "R6";
      end else begin
        r  = {sg, 7'(pick)};
        un = (x < grid(8)) && ix;
        if (un) tag = "R5 R7";
        else if (ix) tag = "R4 R7 R2";
        else tag = "R3 R2";
      end
    end
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic       d1v, d2v;
    logic [7:0] d1a, d1b, d2a, d2b;
    logic [7:0] er;
    logic       eo, eu, ei;
    string      tag;
    int         idx, cyc;
    rst_ni = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    d1v = 0; d2v = 0; d1a = '0; d1b = '0; d2a = '0; d2b = '0;
    idx = 0; cyc = 0;
    repeat (3) @(negedge clk);
    // R11
    n_cmp++;
    if (out_valid !== 1'b0 || result !== 8'h00 || ovf !== 1'b0 || unf !== 1'b0 || inx !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got v=%b r=%h o=%b u=%b i=%b exp all zero",
               out_valid, result, ovf, unf, inx);
    end
    rst_ni = 1'b1;
    while (idx < 65536 || d1v || d2v) begin
      @(negedge clk);
      // R1
      n_cmp++;
      if (out_valid !== d2v) begin
        n_bad++;
        $display("FAIL R1 valid: got %b exp %b", out_valid, d2v);
      end
      if (d2v) begin
        ref_mul(d2a, d2b, er, eo, eu, ei, tag);
        n_cmp++;
        if (result !== er || ovf !== eo || unf !== eu || inx !== ei) begin
          n_bad++;
          $display("FAIL %s a=%h b=%h: got r=%h o=%b u=%b i=%b exp r=%h o=%b u=%b i=%b",
                   tag, d2a, d2b, result, ovf, unf, inx, er, eo, eu, ei);
        end
      end
      d2v = d1v; d2a = d1a; d2b = d1b;
      if (idx < 65536 && (cyc % 53) != 7) begin
        op_a = idx[15:8]; op_b = idx[7:0]; in_valid = 1'b1;
        d1v = 1; d1a = idx[15:8]; d1b = idx[7:0];
        idx++;
      end else begin
        in_valid = 1'b0; d1v = 0;
      end
      cyc++;
    end
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      finish_run();
    end
  end
endmodule